// File: doc/BRIEF.md
# DMA Controller Global Register Block

This block holds the controller-wide state of a 32-channel DMA engine. It is reached through a small 32-bit memory-mapped register port and keeps four things: the controller control word, the per-channel interrupt-pending vector, the descriptor-fetch doorbell and the channel-programmable mask. The control word holds four fields: a global enable, a performance-mode bit, and two sticky global flags for address errors and halts.

Each channel engine reports a one-cycle completion pulse, a halt event and an address-error event. Completions set that channel's pending bit. Halt and address-error events from any channel set the matching global flag. Software clears pending bits and flags by writing zeros over them. A write of ones cannot set them, so software clears exactly what it has serviced. A write to the doorbell sends a one-cycle fetch-start strobe to every channel whose bit was written as 1. A single interrupt line is high while the controller is enabled and any channel is pending.

Top module: `dmag_top`

## Requirements
- R1: After reset the control word, pending vector and programmable mask read 0, `fetch_o` is 0 and `irq_o` is 0.
- R2: A write to byte offset 0x1000 stores bit 0 (enable, on `ctrl_en_o`) and bit 31 (performance mode, on `perf_o`). A read of 0x1000 returns those bits in place. Bits 1 and 4 to 30 always read 0.
- R3: Bit 3 of 0x1000 (halt flag) is set the cycle after any `chan_halt_i` bit is high. Bit 2 (address-error flag) is set the cycle after any `chan_aerr_i` bit is high. A write with a flag bit at 0 clears that flag, and a write with it at 1 leaves it unchanged.
- R4: A halt or address-error event in the same cycle as a write that clears the flag leaves the flag set.
- R5: A high `chan_done_i[n]` sets bit n of the pending vector, read at offset 0x1004, in the next cycle.
- R6: A write to 0x1004 clears each pending bit written as 0 and leaves each bit written as 1 unchanged. It never sets a bit.
- R7: A completion pulse in the same cycle as a write that clears that channel's pending bit leaves the bit set.
- R8: A write to 0x100C drives `fetch_o` equal to the written data for exactly one cycle, the cycle after the write. Otherwise `fetch_o` is 0. A read of 0x100C returns 0.
- R9: Offset 0x101C is a read/write programmable-mask register, driven on `prog_mask_o`. It changes only when written.
- R10: `irq_o` is high exactly when the enable bit is 1 and at least one pending bit is 1.
- R11: A read of any other offset returns 0, and a write to it changes no state. `rdata_o` is 0 whenever no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 13 | Byte address of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| chan_done_i | input | 32 | Per-channel completion pulses |
| chan_halt_i | input | 32 | Per-channel halt events |
| chan_aerr_i | input | 32 | Per-channel address-error events |
| fetch_o | output | 32 | Per-channel descriptor-fetch strobes |
| prog_mask_o | output | 32 | Channel-programmable mask |
| ctrl_en_o | output | 1 | Controller enable |
| perf_o | output | 1 | Performance-mode enable |
| irq_o | output | 1 | Combined interrupt |

## Verification
A hardware set and a software clear can arrive in the same cycle on two kinds of state. One is a channel completion against a pending-register write. The other is a halt or address-error event against a control-word write. The bench drives the event and the clearing write on the same falling edge, so both land on one rising edge. It then reads the register back and expects the hardware-set bit still to be 1, with every other bit cleared as written.

// File: rtl/dmag_pkg.sv
package dmag_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 13;

  localparam logic [AW-1:0] OFS_CTRL = 13'h1000;
  localparam logic [AW-1:0] OFS_PEND = 13'h1004;
  localparam logic [AW-1:0] OFS_BELL = 13'h100C;
  localparam logic [AW-1:0] OFS_MASK = 13'h101C;

  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_AERR = 2;
  localparam int unsigned BIT_HALT = 3;
  localparam int unsigned BIT_PERF = 31;

  typedef struct packed {
    logic ctrl;
    logic pend;
    logic bell;
    logic mask;
  } sel_t;
endpackage

// File: rtl/dmag_decode.sv
module dmag_decode
  import dmag_pkg::*;
(
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output sel_t          wr_o,
  output sel_t          rd_o
);
  sel_t hit;

  always_comb begin
    hit.ctrl = (addr_i == OFS_CTRL);
    hit.pend = (addr_i == OFS_PEND);
    hit.bell = (addr_i == OFS_BELL);
    hit.mask = (addr_i == OFS_MASK);
    wr_o = (req_i &&  we_i) ? hit : '0;
    rd_o = (req_i && !we_i) ? hit : '0;
  end
endmodule

// File: rtl/dmag_ctrl.sv
module dmag_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic en_d_i,
  input  logic perf_d_i,
  input  logic halt_keep_i,
  input  logic aerr_keep_i,
  input  logic halt_ev_i,
  input  logic aerr_ev_i,
  output logic en_o,
  output logic perf_o,
  output logic halt_o,
  output logic aerr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      perf_o <= 1'b0;
      halt_o <= 1'b0;
      aerr_o <= 1'b0;
    end else begin
      if (wr_i) begin
        en_o   <= en_d_i;
        perf_o <= perf_d_i;
      end
      // event wins over a clearing write
      halt_o <= (halt_o & (~wr_i | halt_keep_i)) | halt_ev_i;
      aerr_o <= (aerr_o & (~wr_i | aerr_keep_i)) | aerr_ev_i;
    end
  end
endmodule

// File: rtl/dmag_pend.sv
module dmag_pend #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [NUM_CH-1:0] keep_i,
  input  logic [NUM_CH-1:0] done_i,
  output logic [NUM_CH-1:0] pend_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_o[i] <= 1'b0;
      else         pend_o[i] <= (pend_o[i] & (~wr_i | keep_i[i])) | done_i[i];
    end
  end
endmodule

// File: rtl/dmag_top.sv
module dmag_top
  import dmag_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NUM_CH-1:0] chan_done_i,
  input  logic [NUM_CH-1:0] chan_halt_i,
  input  logic [NUM_CH-1:0] chan_aerr_i,
  output logic [NUM_CH-1:0] fetch_o,
  output logic [NUM_CH-1:0] prog_mask_o,
  output logic              ctrl_en_o,
  output logic              perf_o,
  output logic              irq_o
);
  sel_t wr_sel, rd_sel;
  logic halt_q, aerr_q;
  logic [NUM_CH-1:0] pend_q;

  dmag_decode i_decode (
    .req_i (req_i),
    .we_i  (we_i),
    .addr_i(addr_i),
    .wr_o  (wr_sel),
    .rd_o  (rd_sel)
  );

  dmag_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_sel.ctrl),
    .en_d_i     (wdata_i[BIT_EN]),
    .perf_d_i   (wdata_i[BIT_PERF]),
    .halt_keep_i(wdata_i[BIT_HALT]),
    .aerr_keep_i(wdata_i[BIT_AERR]),
    .halt_ev_i  (|chan_halt_i),
    .aerr_ev_i  (|chan_aerr_i),
    .en_o       (ctrl_en_o),
    .perf_o     (perf_o),
    .halt_o     (halt_q),
    .aerr_o     (aerr_q)
  );

  dmag_pend #(.NUM_CH(NUM_CH)) i_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (wr_sel.pend),
    .keep_i(wdata_i[NUM_CH-1:0]),
    .done_i(chan_done_i),
    .pend_o(pend_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_o     <= '0;
      prog_mask_o <= '0;
    end else begin
      fetch_o <= wr_sel.bell ? wdata_i[NUM_CH-1:0] : '0;
      if (wr_sel.mask) prog_mask_o <= wdata_i[NUM_CH-1:0];
    end
  end

  assign irq_o = ctrl_en_o & (|pend_q);

  always_comb begin
    rdata_o = '0;
    if (rd_sel.ctrl) begin
      rdata_o[BIT_EN]   = ctrl_en_o;
      rdata_o[BIT_AERR] = aerr_q;
      rdata_o[BIT_HALT] = halt_q;
      rdata_o[BIT_PERF] = perf_o;
    end
    if (rd_sel.pend) rdata_o[NUM_CH-1:0] = pend_q;
    if (rd_sel.mask) rdata_o[NUM_CH-1:0] = prog_mask_o;
  end
endmodule

// File: rtl/dmag_chk.sv
module dmag_chk
  import dmag_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [AW-1:0]     addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [NUM_CH-1:0] chan_done_i,
  input logic [NUM_CH-1:0] fetch_o,
  input logic [NUM_CH-1:0] prog_mask_o,
  input logic              ctrl_en_o,
  input logic              irq_o
);
  logic wr_ctrl, wr_bell, wr_mask;
  assign wr_ctrl = req_i && we_i && (addr_i == OFS_CTRL);
  assign wr_bell = req_i && we_i && (addr_i == OFS_BELL);
  assign wr_mask = req_i && we_i && (addr_i == OFS_MASK);

  AST_FETCH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_bell |=> fetch_o == $past(wdata_i[NUM_CH-1:0])); // R8
  AST_FETCH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_bell |=> fetch_o == '0); // R8
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask |=> $stable(prog_mask_o)); // R9
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl |=> $stable(ctrl_en_o)); // R2
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_en_o |-> !irq_o); // R10
  AST_DONE_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_en_o && !wr_ctrl && (|chan_done_i)) |=> irq_o); // R5
endmodule

bind dmag_top dmag_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .chan_done_i(chan_done_i),
  .fetch_o    (fetch_o),
  .prog_mask_o(prog_mask_o),
  .ctrl_en_o  (ctrl_en_o),
  .irq_o      (irq_o)
);

// File: tb/test_dmag_top.sv
module test_dmag_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [12:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] done = '0, halt = '0, aerr = '0;
  logic [31:0] fetch, pmask;
  logic        en, perf, irq;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  dmag_top i_dmag_top (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .chan_done_i(done), .chan_halt_i(halt),
    .chan_aerr_i(aerr), .fetch_o(fetch), .prog_mask_o(pmask),
    .ctrl_en_o(en), .perf_o(perf), .irq_o(irq)
  );

  localparam int NV = 8;
  localparam logic [12:0] V_ADDR [NV] = '{13'h1000, 13'h1000, 13'h101C, 13'h1008,
                                          13'h0000, 13'h100C, 13'h1004, 13'h1000};
  localparam logic [31:0] V_WR   [NV] = '{32'h8000_0001, 32'hFFFF_FFFF, 32'hA5A5_0F0F,
                                          32'hFFFF_FFFF, 32'h0000_1234, 32'h0000_FFFF,
                                          32'hFFFF_FFFF, 32'h0000_0000};
  localparam logic [31:0] V_EXP  [NV] = '{32'h8000_0001, 32'h8000_0001, 32'hA5A5_0F0F,
                                          32'h0, 32'h0, 32'h0, 32'h0, 32'h0};

  task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #2 d = rdata;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic pulse(input int kind, input logic [31:0] v);
    @(negedge clk);
    if (kind == 0) done = v; else if (kind == 1) halt = v; else aerr = v;
    @(negedge clk); done = '0; halt = '0; aerr = '0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(13'h1000, r); check("R1 ctrl", r, 32'h0);
    rd(13'h1004, r); check("R1 pend", r, 32'h0);
    rd(13'h101C, r); check("R1 mask", r, 32'h0);
    check("R1 fetch", fetch, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // table walk: R2 R3 R6 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      wr(V_ADDR[i], V_WR[i]);
      rd(V_ADDR[i], r);
      check($sformatf("R2/R3/R6/R8/R9/R11 vec%0d", i), r, V_EXP[i]);
    end
    check("R9 mask port", pmask, 32'hA5A5_0F0F);
    check("R2 perf/en ports", {30'b0, perf, en}, 32'h0);

    // R5 / R10
    pulse(0, 32'h0000_0020);
    rd(13'h1004, r); check("R5 pend set", r, 32'h0000_0020);
    check("R10 irq off when disabled", {31'b0, irq}, 32'h0);
    wr(13'h1000, 32'h0000_0001);
    #2 check("R10 irq on", {31'b0, irq}, 32'h1);

    // R6 selective clear
    pulse(0, 32'h0000_0200);
    wr(13'h1004, 32'hFFFF_FDFF);
    rd(13'h1004, r); check("R6 clear by zero", r, 32'h0000_0020);

    // R7 done collides with clear
    @(negedge clk); req = 1'b1; we = 1'b1; addr = 13'h1004; wdata = 32'h0; done = 32'h8;
    @(negedge clk); req = 1'b0; we = 1'b0; done = '0;
    rd(13'h1004, r); check("R7 done beats clear", r, 32'h0000_0008);
    wr(13'h1004, 32'h0);
    #2 check("R10 irq drops", {31'b0, irq}, 32'h0);

    // R3 flags
    pulse(1, 32'h0000_0080);
    rd(13'h1000, r); check("R3 halt flag", r, 32'h0000_0009);
    pulse(2, 32'h8000_0000);
    rd(13'h1000, r); check("R3 aerr flag", r, 32'h0000_000D);
    wr(13'h1000, 32'h8000_0005);
    rd(13'h1000, r); check("R3 clear halt keep aerr", r, 32'h8000_0005);
    wr(13'h1000, 32'h8000_0001);
    rd(13'h1000, r); check("R3 clear aerr", r, 32'h8000_0001);

    // R4 halt collides with clear
    @(negedge clk); req = 1'b1; we = 1'b1; addr = 13'h1000; wdata = 32'h1; halt = 32'h2;
    @(negedge clk); req = 1'b0; we = 1'b0; halt = '0;
    rd(13'h1000, r); check("R4 halt beats clear", r, 32'h0000_0009);

    // R8 doorbell strobe
    @(negedge clk); req = 1'b1; we = 1'b1; addr = 13'h100C; wdata = 32'h0000_8421;
    @(negedge clk); req = 1'b0; we = 1'b0;
    check("R8 fetch pulse", fetch, 32'h0000_8421);
    @(negedge clk);
    check("R8 fetch ends", fetch, 32'h0);

    // R11 write to unmapped offset leaves state
    wr(13'h1010, 32'hFFFF_FFFF);
    rd(13'h101C, r); check("R11 mask unchanged", r, 32'hA5A5_0F0F);
    rd(13'h1000, r); check("R11 ctrl unchanged", r, 32'h0000_0009);
    #2 check("R11 idle rdata", rdata, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule